// File: doc/BRIEF.md
# Dual-Channel Thermal Monitor Controller

This block watches two temperature-sensor channels without software help. Once its run bit is set, a free-running tick timer starts a conversion round at a fixed interval. Each round converts source 0 and then source 1 through a request/acknowledge handshake to an external ADC. Every 12-bit result is stored per source and compared against three programmed codes: a high-interrupt code, a shutdown code and a low-interrupt code. While the latest result of any source sits at or above its high-interrupt code, the round interval switches to a second, separately programmed value.

High-interrupt and shutdown conditions act only after a programmed number of consecutive qualifying samples. Each condition has its own 8-bit count. The low condition acts on a single sample. Interrupt events collect as write-one-to-clear pending bits and drive one level interrupt line. A debounced shutdown condition latches per source. It is steered to a reset-unit pin, a GPIO pin or both, and a polarity bit sets the level of both pins.

Register map (byte addresses, 32-bit data, read is combinational on `reg_addr`): 0x00 control (bit 0 run, bit 8 shutdown polarity, 1 = active high); 0x04 enables; 0x08 pending; 0x0C normal period; 0x10 hot period; 0x14 interrupt debounce; 0x18 shutdown debounce; 0x20/0x24 result of source 0/1 (read only); 0x40/0x44 high code; 0x50/0x54 shutdown code; 0x60/0x64 low code.

Top module: `thermal_mon`

## Requirements
- R1: After reset, `irq` and `adc_req` are 0, both shutdown pins are 1 (polarity active low), the pending and result registers read 0, both periods read 1875, both debounce counts read 4.
- R2: With the run bit set, a round starts every normal-period ticks (a period of 0 acts as 1). The first request is source 0 and the second is source 1. `adc_req` and `adc_chan` hold until `adc_ack`, and the acknowledged `adc_code` appears in that source's result register.
- R3: While the latest result of either source is at or above that source's high code, the interval between round starts is the hot period instead.
- R4: Pending bit s (s = 0, 1) is set on a sample of source s once the count of consecutive samples at or above its high code reaches the interrupt debounce count (0 acts as 1), provided enable bit s is 1. A sample below the code returns the count to zero.
- R5: A sample of source s below its low code sets pending bit 12+s when enable bit 12+s is 1.
- R6: Every accepted conversion sets pending bit 16 when enable bit 16 is 1.
- R7: Writing 1 to a pending bit among 0, 1, 12, 13 and 16 clears it, and writing 0 leaves it. `irq` is 1 exactly when some such pending bit has its enable bit set.
- R8: Once the consecutive count at or above the shutdown code reaches the shutdown debounce count, source s latches shutdown and pending bit 4+s reads 1. The GPIO pin is active if some latched source has enable bit 4+s. The reset pin is active if some latched source has enable bit 8+s. Active means the level of control bit 8.
- R9: A latched shutdown is not cleared by writes to the pending register. It clears only on reset or when the run bit is 0.
- R10: With the run bit 0, no conversion is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| adc_req | output | 1 | Conversion request, held until acknowledged |
| adc_chan | output | 1 | Source to convert |
| adc_ack | input | 1 | Conversion done; `adc_code` valid |
| adc_code | input | 12 | Conversion result |
| irq | output | 1 | Combined interrupt level |
| shut_rst_o | output | 1 | Shutdown to the reset unit |
| shut_gpio_o | output | 1 | Shutdown to the GPIO pin |

## Verification
On every cycle, the assertions check these rules: the request holds with its source until acknowledged, no request follows a cleared run bit, a latched shutdown never drops while running and clears once the run bit falls, an active shutdown pin always has a latched source behind it, and the interrupt only rises after a sample or a register write. The debounce counting is shown only by the bench scenarios: a streak broken by a low sample, and pending patterns from random codes placed near the thresholds. The same holds for the exact interval lengths in normal and hot operation, the pin levels under both polarities, and the survival of latched status across clear writes.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  localparam int DEB_W = 8;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_IEN  = 8'h04;
  localparam logic [7:0] A_PEND = 8'h08;
  localparam logic [7:0] A_PER  = 8'h0C;
  localparam logic [7:0] A_PERH = 8'h10;
  localparam logic [7:0] A_DEBI = 8'h14;
  localparam logic [7:0] A_DEBS = 8'h18;
  localparam int         A_DATA = 'h20;
  localparam int         A_HI   = 'h40;
  localparam int         A_SH   = 'h50;
  localparam int         A_LO   = 'h60;

  localparam int B_HI  = 0;
  localparam int B_SHG = 4;
  localparam int B_SHR = 8;
  localparam int B_LO  = 12;
  localparam int B_EOC = 16;

  typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_state_t;

  function automatic logic [31:0] bits_at(input int base, input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[base + i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DEB_W-1:0] deb_step(input logic [DEB_W-1:0] cnt,
                                                input logic cond);
    if (!cond) return '0;
    if (cnt == {DEB_W{1'b1}}) return cnt;
    return cnt + 1'b1;
  endfunction

  function automatic logic deb_reached(input logic [DEB_W-1:0] cnt,
                                       input logic [DEB_W-1:0] lim);
    if (lim == '0) return cnt != '0;
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/thermal_src.sv
module thermal_src
  import thermal_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             smp_hit,
  input  logic [CW-1:0]    smp_code,
  input  logic [CW-1:0]    thr_hi,
  input  logic [CW-1:0]    thr_sh,
  input  logic [CW-1:0]    thr_lo,
  input  logic [DEB_W-1:0] deb_int,
  input  logic [DEB_W-1:0] deb_sh,
  output logic [CW-1:0]    data_q,
  output logic             hot,
  output logic             hi_fire,
  output logic             lo_fire,
  output logic             sh_fire,
  output logic             shut_lat
);
  logic [DEB_W-1:0] hi_cnt, sh_cnt, hi_nx, sh_nx;
  logic             hi_cond, sh_cond;

  assign hi_cond = smp_code >= thr_hi;
  assign sh_cond = smp_code >= thr_sh;
  assign hi_nx   = deb_step(hi_cnt, hi_cond);
  assign sh_nx   = deb_step(sh_cnt, sh_cond);
  assign hi_fire = smp_hit && deb_reached(hi_nx, deb_int);
  assign sh_fire = smp_hit && deb_reached(sh_nx, deb_sh);
  assign lo_fire = smp_hit && (smp_code < thr_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      hi_cnt   <= '0;
      sh_cnt   <= '0;
      hot      <= 1'b0;
      shut_lat <= 1'b0;
    end else begin
      if (smp_hit) data_q <= smp_code;
      if (!auto_en) begin
        hi_cnt   <= '0;
        sh_cnt   <= '0;
        hot      <= 1'b0;
        shut_lat <= 1'b0;
      end else if (smp_hit) begin
        hi_cnt   <= hi_nx;
        sh_cnt   <= sh_nx;
        hot      <= hi_cond;
        shut_lat <= shut_lat | sh_fire;
      end
    end
  end
endmodule

// File: rtl/thermal_seq.sv
module thermal_seq
  import thermal_pkg::*;
#(
  parameter int NSRC = 2,
  parameter int CW   = 12,
  parameter int PW   = 32,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_en,
  input  logic          hot,
  input  logic [PW-1:0] per_norm,
  input  logic [PW-1:0] per_hot,
  output logic          adc_req,
  output logic [SW-1:0] adc_chan,
  input  logic          adc_ack,
  input  logic [CW-1:0] adc_code,
  output logic          smp_vld,
  output logic [SW-1:0] smp_ch,
  output logic [CW-1:0] smp_code,
  output logic          round_start
);
  seq_state_t    state;
  logic [PW-1:0] tmr, per_sel, per_lim;
  logic          due, wrap;

  assign per_sel     = hot ? per_hot : per_norm;
  assign per_lim     = (per_sel == '0) ? PW'(1) : per_sel;
  assign wrap        = tmr >= (per_lim - 1'b1);
  assign round_start = (state == SEQ_IDLE) && due;
  assign adc_req     = (state == SEQ_BUSY);
  assign smp_vld     = adc_req && adc_ack;
  assign smp_ch      = adc_chan;
  assign smp_code    = adc_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      tmr      <= '0;
      due      <= 1'b0;
      adc_chan <= '0;
    end else if (!auto_en) begin
      state    <= SEQ_IDLE;
      tmr      <= '0;
      due      <= 1'b0;
      adc_chan <= '0;
    end else begin
      tmr <= wrap ? '0 : tmr + 1'b1;
      due <= (due && !round_start) || wrap;
      case (state)
        SEQ_IDLE: if (due) begin
          state    <= SEQ_BUSY;
          adc_chan <= '0;
        end
        SEQ_BUSY: if (adc_ack) begin
          if (adc_chan == SW'(NSRC - 1)) state <= SEQ_IDLE;
          else adc_chan <= adc_chan + 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/thermal_regs.sv
module thermal_regs
  import thermal_pkg::*;
#(
  parameter int NSRC       = 2,
  parameter int CW         = 12,
  parameter int PW         = 32,
  parameter int DEF_PERIOD = 1875,
  parameter int DEF_DEB    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [7:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic [NSRC-1:0][CW-1:0]   data_q,
  input  logic [NSRC-1:0]           shut_lat,
  input  logic [NSRC-1:0]           hi_set,
  input  logic [NSRC-1:0]           lo_set,
  input  logic                      eoc_set,
  output logic                      auto_en,
  output logic                      pol,
  output logic [31:0]               en_q,
  output logic [31:0]               pend_q,
  output logic [NSRC-1:0][CW-1:0]   thr_hi,
  output logic [NSRC-1:0][CW-1:0]   thr_sh,
  output logic [NSRC-1:0][CW-1:0]   thr_lo,
  output logic [PW-1:0]             per_norm,
  output logic [PW-1:0]             per_hot,
  output logic [DEB_W-1:0]          deb_int,
  output logic [DEB_W-1:0]          deb_sh,
  output logic                      irq
);
  localparam logic [31:0] IRQ_MASK = bits_at(B_HI, NSRC) | bits_at(B_LO, NSRC)
                                   | bits_at(B_EOC, 1);
  localparam logic [31:0] EN_MASK  = IRQ_MASK | bits_at(B_SHG, NSRC)
                                   | bits_at(B_SHR, NSRC);

  logic [31:0] set_v, clr_v, pend_nx, pend_view;

  always_comb begin
    set_v = '0;
    for (int s = 0; s < NSRC; s++) begin
      set_v[B_HI + s] = hi_set[s] && en_q[B_HI + s];
      set_v[B_LO + s] = lo_set[s] && en_q[B_LO + s];
    end
    set_v[B_EOC] = eoc_set && en_q[B_EOC];
    clr_v   = (reg_wr && reg_addr == A_PEND) ? (reg_wdata & IRQ_MASK) : '0;
    pend_nx = (pend_q & ~clr_v) | set_v;
  end

  always_comb begin
    pend_view = pend_q;
    for (int s = 0; s < NSRC; s++) pend_view[B_SHG + s] = shut_lat[s];
  end

  assign irq = |(pend_q & en_q & IRQ_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_en  <= 1'b0;
      pol      <= 1'b0;
      en_q     <= '0;
      pend_q   <= '0;
      per_norm <= PW'(DEF_PERIOD);
      per_hot  <= PW'(DEF_PERIOD);
      deb_int  <= DEB_W'(DEF_DEB);
      deb_sh   <= DEB_W'(DEF_DEB);
      for (int s = 0; s < NSRC; s++) begin
        thr_hi[s] <= '1;
        thr_sh[s] <= '1;
        thr_lo[s] <= '0;
      end
    end else begin
      pend_q <= pend_nx;
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: begin
            auto_en <= reg_wdata[0];
            pol     <= reg_wdata[8];
          end
          A_IEN:  en_q     <= reg_wdata & EN_MASK;
          A_PER:  per_norm <= reg_wdata[PW-1:0];
          A_PERH: per_hot  <= reg_wdata[PW-1:0];
          A_DEBI: deb_int  <= reg_wdata[DEB_W-1:0];
          A_DEBS: deb_sh   <= reg_wdata[DEB_W-1:0];
          default: ;
        endcase
        for (int s = 0; s < NSRC; s++) begin
          if (reg_addr == 8'(A_HI + 4 * s)) thr_hi[s] <= reg_wdata[CW-1:0];
          if (reg_addr == 8'(A_SH + 4 * s)) thr_sh[s] <= reg_wdata[CW-1:0];
          if (reg_addr == 8'(A_LO + 4 * s)) thr_lo[s] <= reg_wdata[CW-1:0];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = {23'b0, pol, 7'b0, auto_en};
      A_IEN:  reg_rdata = en_q;
      A_PEND: reg_rdata = pend_view;
      A_PER:  reg_rdata = 32'(per_norm);
      A_PERH: reg_rdata = 32'(per_hot);
      A_DEBI: reg_rdata = 32'(deb_int);
      A_DEBS: reg_rdata = 32'(deb_sh);
      default: ;
    endcase
    for (int s = 0; s < NSRC; s++) begin
      if (reg_addr == 8'(A_DATA + 4 * s)) reg_rdata = 32'(data_q[s]);
      if (reg_addr == 8'(A_HI + 4 * s))   reg_rdata = 32'(thr_hi[s]);
      if (reg_addr == 8'(A_SH + 4 * s))   reg_rdata = 32'(thr_sh[s]);
      if (reg_addr == 8'(A_LO + 4 * s))   reg_rdata = 32'(thr_lo[s]);
    end
  end
endmodule

// File: rtl/thermal_mon.sv
module thermal_mon
  import thermal_pkg::*;
#(
  parameter int NSRC       = 2,
  parameter int CW         = 12,
  parameter int PW         = 32,
  parameter int DEF_PERIOD = 1875,
  parameter int DEF_DEB    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [7:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    adc_req,
  output logic [$clog2(NSRC)-1:0] adc_chan,
  input  logic                    adc_ack,
  input  logic [CW-1:0]           adc_code,
  output logic                    irq,
  output logic                    shut_rst_o,
  output logic                    shut_gpio_o
);
  localparam int SW = $clog2(NSRC);

  logic                    auto_en, pol, hot, round_start;
  logic [31:0]             en_q, pend_q;
  logic [NSRC-1:0][CW-1:0] data_q, thr_hi, thr_sh, thr_lo;
  logic [PW-1:0]           per_norm, per_hot;
  logic [DEB_W-1:0]        deb_int, deb_sh;
  logic [NSRC-1:0]         hot_v, hi_fire, lo_fire, sh_fire, shut_lat;
  logic                    smp_vld;
  logic [SW-1:0]           smp_ch;
  logic [CW-1:0]           smp_code;
  logic                    act_gpio, act_rst;

  assign hot = |hot_v;

  thermal_seq #(.NSRC(NSRC), .CW(CW), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .hot(hot),
    .per_norm(per_norm), .per_hot(per_hot),
    .adc_req(adc_req), .adc_chan(adc_chan), .adc_ack(adc_ack),
    .adc_code(adc_code), .smp_vld(smp_vld), .smp_ch(smp_ch),
    .smp_code(smp_code), .round_start(round_start)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    thermal_src #(.CW(CW)) u_src (
      .clk(clk), .rst_n(rst_n), .auto_en(auto_en),
      .smp_hit(smp_vld && (smp_ch == SW'(g))), .smp_code(smp_code),
      .thr_hi(thr_hi[g]), .thr_sh(thr_sh[g]), .thr_lo(thr_lo[g]),
      .deb_int(deb_int), .deb_sh(deb_sh),
      .data_q(data_q[g]), .hot(hot_v[g]),
      .hi_fire(hi_fire[g]), .lo_fire(lo_fire[g]), .sh_fire(sh_fire[g]),
      .shut_lat(shut_lat[g])
    );
  end

  thermal_regs #(.NSRC(NSRC), .CW(CW), .PW(PW), .DEF_PERIOD(DEF_PERIOD),
                 .DEF_DEB(DEF_DEB)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .data_q(data_q), .shut_lat(shut_lat), .hi_set(hi_fire),
    .lo_set(lo_fire), .eoc_set(smp_vld),
    .auto_en(auto_en), .pol(pol), .en_q(en_q), .pend_q(pend_q),
    .thr_hi(thr_hi), .thr_sh(thr_sh), .thr_lo(thr_lo),
    .per_norm(per_norm), .per_hot(per_hot),
    .deb_int(deb_int), .deb_sh(deb_sh), .irq(irq)
  );

  assign act_gpio    = |(shut_lat & en_q[B_SHG +: NSRC]);
  assign act_rst     = |(shut_lat & en_q[B_SHR +: NSRC]);
  assign shut_gpio_o = pol ? act_gpio : !act_gpio;
  assign shut_rst_o  = pol ? act_rst : !act_rst;
endmodule

// File: rtl/thermal_mon_chk.sv
module thermal_mon_chk #(
  parameter int NSRC = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr,
  input logic                    adc_req,
  input logic [$clog2(NSRC)-1:0] adc_chan,
  input logic                    adc_ack,
  input logic                    irq,
  input logic                    shut_rst_o,
  input logic                    shut_gpio_o,
  input logic                    auto_en,
  input logic                    pol,
  input logic                    smp_vld,
  input logic [NSRC-1:0]         shut_lat
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req && !adc_ack |=> adc_req && $stable(adc_chan)); // R2

  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !adc_req); // R10

  AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en |=> ((shut_lat & $past(shut_lat)) == $past(shut_lat))); // R9

  AST_SHUT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> shut_lat == '0); // R9

  AST_PIN_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_gpio_o == pol) || (shut_rst_o == pol) |-> shut_lat != '0); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(smp_vld || reg_wr)); // R7
endmodule

bind thermal_mon thermal_mon_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .adc_req(adc_req),
  .adc_chan(adc_chan), .adc_ack(adc_ack), .irq(irq),
  .shut_rst_o(shut_rst_o), .shut_gpio_o(shut_gpio_o),
  .auto_en(auto_en), .pol(pol), .smp_vld(smp_vld), .shut_lat(shut_lat)
);

// File: tb/thermal_mon_test.sv
module thermal_mon_test;
  localparam logic [7:0] CTRL = 8'h00, IEN = 8'h04, PEND = 8'h08, PER = 8'h0C,
                         PERH = 8'h10, DEBI = 8'h14, DEBS = 8'h18,
                         DAT0 = 8'h20, DAT1 = 8'h24, HI0 = 8'h40, HI1 = 8'h44,
                         SH0 = 8'h50, SH1 = 8'h54, LO0 = 8'h60, LO1 = 8'h64;
  localparam logic [31:0] EN_IRQ = 32'h0001_3003;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        adc_req, adc_ack;
  logic [0:0]  adc_chan;
  logic [11:0] adc_code;
  logic        irq, shut_rst_o, shut_gpio_o;

  always #5 clk = ~clk;

  thermal_mon uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_req(adc_req),
    .adc_chan(adc_chan), .adc_ack(adc_ack), .adc_code(adc_code),
    .irq(irq), .shut_rst_o(shut_rst_o), .shut_gpio_o(shut_gpio_o)
  );

  int checks = 0, fails = 0;
  int rounds_done = 0, req_rises = 0, cyc = 0, last_rise = 0, gap = 0;
  logic [11:0] model_code [2];
  logic [11:0] cfg_hi [2], cfg_lo [2];
  int  cnt_hi [2];
  int  cfg_deb = 4;
  logic [31:0] exp_pend = '0, rdv;
  bit  finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // ADC model: acknowledges after 0..2 cycles with the code for the source
  initial begin
    int dly;
    dly = 0; adc_ack = 1'b0; adc_code = '0;
    forever begin
      @(negedge clk);
      if (adc_ack) adc_ack = 1'b0;
      else if (adc_req) begin
        if (dly == 0) begin
          adc_ack = 1'b1;
          adc_code = model_code[adc_chan];
          if (adc_chan == 1'b1) rounds_done++;
          dly = $urandom % 3;
        end else dly--;
      end
    end
  end

  // Measures the spacing between source-0 request rises
  initial begin
    bit prev;
    prev = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (adc_req && adc_chan == 1'b0 && !prev) begin
        gap = cyc - last_rise; last_rise = cyc; req_rises++;
      end
      prev = adc_req && adc_chan == 1'b0;
    end
  end

  function automatic int streak(input int c, input bit cond);
    if (!cond) return 0;
    return (c < 255) ? c + 1 : 255;
  endfunction

  // One conversion round with given codes; updates the expected pending word
  task automatic do_round(input logic [11:0] c0, input logic [11:0] c1);
    int r, lim;
    logic [11:0] c [2];
    c[0] = c0; c[1] = c1;
    model_code[0] = c0; model_code[1] = c1;
    r = rounds_done;
    wait (rounds_done == r + 1);
    repeat (3) @(negedge clk);
    lim = (cfg_deb == 0) ? 1 : cfg_deb;
    for (int s = 0; s < 2; s++) begin
      cnt_hi[s] = streak(cnt_hi[s], c[s] >= cfg_hi[s]);
      if (cnt_hi[s] >= lim) exp_pend[s] = 1'b1;
      if (c[s] < cfg_lo[s]) exp_pend[12 + s] = 1'b1;
    end
    exp_pend[16] = 1'b1;
  endtask

  task automatic check_irq_state(input string tag);
    rd(PEND, rdv);
    chk({tag, " pending"}, rdv & EN_IRQ, exp_pend);
    chk({tag, " irq (R7)"}, {31'b0, irq}, {31'b0, exp_pend != 0});
  endtask

  task automatic clear_all();
    wr(PEND, 32'hFFFF_FFFF);
    exp_pend = '0;
  endtask

  task automatic wait_rounds(input int n);
    int r;
    r = rounds_done;
    wait (rounds_done == r + n);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int rq;
    void'($urandom(32'd11));
    model_code[0] = 12'h100; model_code[1] = 12'h100;
    for (int s = 0; s < 2; s++) begin cnt_hi[s] = 0; cfg_hi[s] = 12'hFFF; cfg_lo[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 adc_req", {31'b0, adc_req}, 32'h0);
    chk("R1 shut pins", {30'b0, shut_gpio_o, shut_rst_o}, 32'h3);
    rd(PEND, rdv); chk("R1 pending", rdv, 32'h0);
    rd(DAT1, rdv); chk("R1 data", rdv, 32'h0);
    rd(PER, rdv);  chk("R1 period", rdv, 32'd1875);
    rd(PERH, rdv); chk("R1 hot period", rdv, 32'd1875);
    rd(DEBI, rdv); chk("R1 int debounce", rdv, 32'd4);
    rd(DEBS, rdv); chk("R1 shut debounce", rdv, 32'd4);
    repeat (20) @(negedge clk);
    chk("R10 idle before run", {31'b0, adc_req}, 32'h0);

    // configure
    wr(PER, 32'd60); wr(PERH, 32'd60);
    cfg_deb = 3; wr(DEBI, 32'd3);
    cfg_hi[0] = 12'h800; cfg_hi[1] = 12'h800; wr(HI0, 32'h800); wr(HI1, 32'h800);
    cfg_lo[0] = 12'h200; cfg_lo[1] = 12'h200; wr(LO0, 32'h200); wr(LO1, 32'h200);
    wr(IEN, EN_IRQ);
    wr(CTRL, 32'h1);

    // R2 data registers and R6 end of conversion
    do_round(12'h345, 12'h456);
    rd(DAT0, rdv); chk("R2 data source 0", rdv, 32'h345);
    rd(DAT1, rdv); chk("R2 data source 1", rdv, 32'h456);
    rd(PEND, rdv); chk("R6 eoc bit", {31'b0, rdv[16]}, 32'h1);
    check_irq_state("R6");
    clear_all();

    // R4 debounce with an interrupted streak; R5 low on source 1
    do_round(12'h900, 12'h100); do_round(12'h900, 12'h100);
    do_round(12'h100, 12'h300); do_round(12'h900, 12'h300);
    do_round(12'h900, 12'h300);
    rd(PEND, rdv); chk("R4 streak broken, no high bit", {31'b0, rdv[0]}, 32'h0);
    chk("R5 low source 1", {31'b0, rdv[13]}, 32'h1);
    do_round(12'h900, 12'h300);
    rd(PEND, rdv); chk("R4 third consecutive sets bit 0", {31'b0, rdv[0]}, 32'h1);
    check_irq_state("R4");

    // R7 partial clear and enable gating
    clear_all();
    do_round(12'h900, 12'h300);
    wr(PEND, 32'h0001_0000); exp_pend[16] = 1'b0;
    rd(PEND, rdv); chk("R7 partial clear keeps bit 0", rdv & EN_IRQ, 32'h1);
    wr(IEN, EN_IRQ & ~32'h1);
    chk("R7 irq masked by enable", {31'b0, irq}, 32'h0);
    wr(IEN, EN_IRQ);
    chk("R7 irq with enable", {31'b0, irq}, 32'h1);
    clear_all();

    // random rounds around the thresholds
    for (int blk = 0; blk < 4; blk++) begin
      cfg_deb = 1 + ($urandom % 3);
      wr(DEBI, cfg_deb);
      for (int k = 0; k < 10; k++) begin
        logic [11:0] c [2];
        for (int s = 0; s < 2; s++)
          c[s] = ($urandom % 4 == 0) ? 12'(12'h1F0 + $urandom % 32)
                                     : 12'(cfg_hi[s] - 8 + $urandom % 16);
        do_round(c[0], c[1]);
        check_irq_state("R4/R5 random");
        clear_all();
      end
    end

    // R2 normal period, R3 hot period
    wr(HI0, 32'hFFF); wr(HI1, 32'hFFF);
    model_code[0] = 12'h100; model_code[1] = 12'h100;
    wr(PER, 32'd25); wr(PERH, 32'd37);
    wait_rounds(3);
    chk("R2 normal round spacing", gap, 32'd25);
    wr(HI0, 32'h050);
    wait_rounds(3);
    chk("R3 hot round spacing", gap, 32'd37);
    wr(HI0, 32'hFFF); wr(PER, 32'd60); wr(PERH, 32'd60);
    cfg_hi[0] = 12'hFFF; cfg_hi[1] = 12'hFFF;
    wait_rounds(1);
    clear_all();

    // R8 shutdown routing and polarity, R9 latch behaviour
    wr(DEBS, 32'd2); wr(SH0, 32'h600); wr(SH1, 32'h600);
    wr(IEN, EN_IRQ | 32'h0000_0210);
    do_round(12'h700, 12'h100);
    chk("R8 one sample not enough", {30'b0, shut_gpio_o, shut_rst_o}, 32'h3);
    do_round(12'h700, 12'h100);
    chk("R8 gpio active low", {30'b0, shut_gpio_o, shut_rst_o}, 32'h1);
    rd(PEND, rdv); chk("R8 status bits", {30'b0, rdv[5:4]}, 32'h1);
    do_round(12'h100, 12'h700); do_round(12'h100, 12'h700);
    chk("R8 reset pin active low", {30'b0, shut_gpio_o, shut_rst_o}, 32'h0);
    wr(PEND, 32'h0000_0030);
    rd(PEND, rdv); chk("R9 clear write ignored", {30'b0, rdv[5:4]}, 32'h3);
    do_round(12'h100, 12'h100);
    chk("R9 latch holds on cool samples", {30'b0, shut_gpio_o, shut_rst_o}, 32'h0);
    wr(CTRL, 32'h101);
    chk("R8 polarity active high", {30'b0, shut_gpio_o, shut_rst_o}, 32'h3);
    wr(CTRL, 32'h100);
    @(negedge clk);
    chk("R9 cleared by run bit", {30'b0, shut_gpio_o, shut_rst_o}, 32'h0);
    rd(PEND, rdv); chk("R9 status cleared", {30'b0, rdv[5:4]}, 32'h0);

    // R10 no requests while stopped
    rq = req_rises;
    repeat (200) @(negedge clk);
    chk("R10 no requests", req_rises - rq, 32'h0);
    chk("R10 adc_req low", {31'b0, adc_req}, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule